// File: doc/BRIEF.md
# Dual-Pointer LIFO Stack Buffer

A synchronous last-in-first-out buffer that holds its entries in a small register array. The number of stored words is one count. Two pointers are derived from that count, so they always move together. The read pointer selects the newest stored word. The write pointer selects the next free slot.

The top-of-stack output is read from the array at the read pointer, with no clock in the path. It reads as zero while the stack holds nothing. A push and a pop in the same cycle are handled in place: the old top word is presented and consumed, the pushed word lands in that same slot, and the count and pointers keep their values. A push on a full stack is accepted only when a pop comes with it. A pop on an empty stack is dropped. The full and empty flags are registered and are computed from the next-cycle count, so they change on the same edge as the count.

Top module: `dp_stack`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `fill_level` becomes 0 and both `is_full` and `is_empty` become 0. On the first edge with `rst_n` high, the flags take their normal values.
- R2: A push with no pop, on a stack that is not full, is accepted. `fill_level` rises by one, and `top_word` shows the pushed word after the edge.
- R3: A pop with no push, on a stack that holds at least one word, is accepted. `fill_level` falls by one, and `top_word` shows the word stored just below the old top.
- R4: A push and a pop together, on a non-empty stack that is not full, replace the top word in place. `fill_level` is unchanged, `top_word` becomes the pushed word, and the words below are unchanged.
- R5: A push with no pop on a full stack is ignored. `fill_level`, `is_full`, `is_empty`, `top_word` and every stored word are unchanged.
- R6: A pop with no push on an empty stack is ignored. `fill_level` stays 0 and `is_empty` stays 1.
- R7: Outside the cycle that directly follows reset, `is_full` equals (`fill_level` == DEPTH) and `is_empty` equals (`fill_level` == 0). Both flags change on the same edge as the count.
- R8: Words come back out in the reverse of the order in which they were pushed.
- R9: `top_word` is 0 whenever `fill_level` is 0. Otherwise it is the most recently stored word that is still present.
- R10: A push and a pop together on an empty stack act as a push alone. `fill_level` becomes 1 and `top_word` becomes the pushed word.
- R11: A push and a pop together on a full stack replace the top word. The stack stays full, with `fill_level` equal to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_en | input | 1 | Request to store `push_word` |
| push_word | input | WIDTH | Word to store |
| pop_en | input | 1 | Request to remove the top word |
| top_word | output | WIDTH | Current top-of-stack word, or 0 when empty |
| fill_level | output | $clog2(DEPTH+1) | Number of stored words |
| is_full | output | 1 | Registered: stack holds DEPTH words |
| is_empty | output | 1 | Registered: stack holds no words |

## Verification
A wrong count shows at `fill_level` and at the flags on the very edge of the faulty operation. Because `top_word` is addressed from the count, the same fault also moves `top_word` to another slot at once. A write to the wrong slot may stay hidden until the stack is popped down to that slot. For this reason the bench fills the stack, replaces words in place at several depths, and then drains it completely, comparing every word that comes out. Ignored pushes and pops are checked in the cycle that follows them, and again later during the drain, so that a silent overwrite is caught.

// File: rtl/lifo_pkg.sv
// Shared types for the dual-pointer stack.
// Assumes: nothing beyond a single clock domain.
package lifo_pkg;

    // Operation accepted in one cycle after qualification of the requests.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stk_op_e;

endpackage

// File: rtl/lifo_ctrl.sv
// Request qualification and next-count computation.
// What it does: decides which operation is accepted this cycle and what the
// occupancy will be after the edge.
// Assumes: count never exceeds DEPTH.
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [CW-1:0] count,
    output stk_op_e       op,
    output logic [CW-1:0] next_count
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic take_push;
    logic take_pop;

    // Accept a push when there is room, or when a pop frees the top slot.
    // Accept a pop only when a word is stored.
    always_comb begin
        take_pop  = pop_req && (count != '0);
        take_push = push_req && ((count != DEPTH_C) || pop_req);
    end

    // Encode the accepted operation and derive the next occupancy.
    always_comb begin
        unique case ({take_push, take_pop})
            2'b10:   begin op = OP_PUSH; next_count = count + CW'(1); end
            2'b01:   begin op = OP_POP;  next_count = count - CW'(1); end
            2'b11:   begin op = OP_SWAP; next_count = count;          end
            default: begin op = OP_IDLE; next_count = count;          end
        endcase
    end

endmodule

// File: rtl/lifo_ptrs.sv
// Read and write pointer derivation.
// What it does: maps the occupancy count to the slot of the newest word
// (read pointer) and the next free slot (write pointer), both modulo DEPTH.
// Assumes: DEPTH >= 2 and count <= DEPTH.
module lifo_ptrs #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [CW-1:0] count,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] wr_ptr
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_C  = PW'(DEPTH - 1);

    logic [CW-1:0] count_m1;

    // The read pointer trails the write pointer by exactly one slot.
    always_comb begin
        count_m1 = count - CW'(1);
        wr_ptr   = (count == DEPTH_C) ? '0 : count[PW-1:0];
        rd_ptr   = (count == '0) ? LAST_C : count_m1[PW-1:0];
    end

endmodule

// File: rtl/lifo_ram.sv
// Entry storage with one write port and one asynchronous read port.
// What it does: on a push writes the word at the write pointer; on an
// in-place replace writes it at the read pointer, after the old word has
// been presented on the read port during the same cycle.
// Assumes: pointers are below DEPTH; contents are not reset.
module lifo_ram
    import lifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 4,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  stk_op_e          op,
    input  logic [PW-1:0]    rd_ptr,
    input  logic [PW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] slot [DEPTH];
    logic             we;
    logic [PW-1:0]    waddr;

    // Pick the write slot: next free slot for a push, top slot for a replace.
    always_comb begin
        we    = (op == OP_PUSH) || (op == OP_SWAP);
        waddr = (op == OP_SWAP) ? rd_ptr : wr_ptr;
    end

    // One register per entry, written only when addressed.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (waddr == PW'(g))) begin
                slot[g] <= wdata;
            end
        end
    end

    // Asynchronous read of the current top slot.
    assign rdata = slot[rd_ptr];

endmodule

// File: rtl/dp_stack.sv
// Dual-pointer LIFO stack buffer (top level).
// What it does: holds up to DEPTH words. It counts them, derives the read and
// write pointers from that count, and drives registered full and empty flags
// computed from the next-cycle count.
// Assumes: synchronous active-low reset; DEPTH >= 2.
module dp_stack
    import lifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [WIDTH-1:0] push_word,
    input  logic             pop_en,
    output logic [WIDTH-1:0] top_word,
    output logic [CW-1:0]    fill_level,
    output logic             is_full,
    output logic             is_empty
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    stk_op_e          op;
    logic [CW-1:0]    next_count;
    logic [PW-1:0]    rd_ptr;
    logic [PW-1:0]    wr_ptr;
    logic [WIDTH-1:0] ram_rdata;

    lifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .push_req   (push_en),
        .pop_req    (pop_en),
        .count      (fill_level),
        .op         (op),
        .next_count (next_count)
    );

    lifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .count  (fill_level),
        .rd_ptr (rd_ptr),
        .wr_ptr (wr_ptr)
    );

    lifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk   (clk),
        .op    (op),
        .rd_ptr(rd_ptr),
        .wr_ptr(wr_ptr),
        .wdata (push_word),
        .rdata (ram_rdata)
    );

    // Occupancy register and flags registered from the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_level <= '0;
            is_full    <= 1'b0;
            is_empty   <= 1'b0;
        end else begin
            fill_level <= next_count;
            is_full    <= (next_count == DEPTH_C);
            is_empty   <= (next_count == '0);
        end
    end

    // Present zero while nothing is stored.
    assign top_word = (fill_level == '0) ? '0 : ram_rdata;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (fill_level == '0) && !is_full && !is_empty); // R1

    AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en && (fill_level != DEPTH_C))
        |=> (fill_level == $past(fill_level) + CW'(1)) && (top_word == $past(push_word))); // R2

    AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en && (fill_level != '0))
        |=> (fill_level == $past(fill_level) - CW'(1))); // R3

    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en && (fill_level != '0))
        |=> $stable(fill_level) && (top_word == $past(push_word))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en && (fill_level == DEPTH_C))
        |=> $stable(fill_level) && $stable(top_word) && is_full); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en && (fill_level == '0))
        |=> (fill_level == '0) && is_empty); // R6

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (is_full == (fill_level == DEPTH_C)) && (is_empty == (fill_level == '0))); // R7

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> (top_word == '0)); // R9

    AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en && (fill_level == '0))
        |=> (fill_level == CW'(1)) && (top_word == $past(push_word))); // R10

endmodule

// File: tb/dp_stack_tb.sv
// Directed bench for dp_stack: one task per scenario, each checking itself
// against a behavioural stack model kept in the bench.
module dp_stack_tb;

    localparam int DEPTH = 4;
    localparam int WIDTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_en = 1'b0;
    logic [WIDTH-1:0] push_word = '0;
    logic             pop_en = 1'b0;
    logic [WIDTH-1:0] top_word;
    logic [CW-1:0]    fill_level;
    logic             is_full;
    logic             is_empty;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [WIDTH-1:0] mdl [DEPTH];
    int               mcnt = 0;

    dp_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_word (push_word),
        .pop_en    (pop_en),
        .top_word  (top_word),
        .fill_level(fill_level),
        .is_full   (is_full),
        .is_empty  (is_empty)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare every port with the model (called at a falling edge).
    task automatic check_all(input string tag);
        check(tag, "fill_level", int'(fill_level), mcnt);
        check(tag, "is_full",    int'(is_full),  int'(mcnt == DEPTH));
        check(tag, "is_empty",   int'(is_empty), int'(mcnt == 0));
        check(tag, "top_word",   int'(top_word), (mcnt == 0) ? 0 : int'(mdl[mcnt-1]));
    endtask

    // Drive one cycle of requests, update the model, then check.
    task automatic step(input bit psh, input bit pp, input logic [WIDTH-1:0] d, input string tag);
        bit acc_push;
        bit acc_pop;
        push_en   = psh;
        pop_en    = pp;
        push_word = d;
        acc_pop  = pp && (mcnt > 0);
        acc_push = psh && ((mcnt < DEPTH) || pp);
        @(negedge clk);
        if (acc_push && acc_pop)      mdl[mcnt-1] = d;
        else if (acc_push)            begin mdl[mcnt] = d; mcnt++; end
        else if (acc_pop)             mcnt--;
        push_en = 1'b0;
        pop_en  = 1'b0;
        check_all(tag);
    endtask

    task automatic t_reset();
        step(1, 0, 4'h3, "R2");
        step(1, 0, 4'h4, "R2");
        rst_n = 1'b0;
        @(negedge clk);
        mcnt = 0;
        check("R1", "fill_level in reset", int'(fill_level), 0);
        check("R1", "is_full in reset",    int'(is_full),  0);
        check("R1", "is_empty in reset",   int'(is_empty), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
    endtask

    task automatic t_underflow();
        step(0, 1, 4'h0, "R6");
        step(0, 1, 4'h0, "R6");
        check("R9", "top_word when empty", int'(top_word), 0);
    endtask

    task automatic t_fill_drain();
        step(1, 0, 4'hA, "R2");
        step(1, 0, 4'h5, "R2");
        step(1, 0, 4'hC, "R2");
        step(1, 0, 4'h7, "R7");
        step(0, 1, 4'h0, "R8");
        step(0, 1, 4'h0, "R8");
        step(0, 1, 4'h0, "R3");
        step(0, 1, 4'h0, "R8");
        check("R9", "top_word after drain", int'(top_word), 0);
    endtask

    task automatic t_overflow();
        step(1, 0, 4'h1, "R2");
        step(1, 0, 4'h2, "R2");
        step(1, 0, 4'h3, "R2");
        step(1, 0, 4'h4, "R7");
        step(1, 0, 4'hF, "R5");
        step(1, 0, 4'hE, "R5");
        step(0, 1, 4'h0, "R5");
        step(0, 1, 4'h0, "R5");
        step(0, 1, 4'h0, "R8");
        step(0, 1, 4'h0, "R8");
    endtask

    task automatic t_swap_mid();
        step(1, 0, 4'h9, "R2");
        step(1, 0, 4'h8, "R2");
        step(1, 1, 4'h6, "R4");
        step(1, 1, 4'hB, "R4");
        step(0, 1, 4'h0, "R4");
        step(1, 1, 4'hD, "R4");
        step(0, 1, 4'h0, "R8");
    endtask

    task automatic t_swap_full();
        for (int i = 0; i < DEPTH; i++) step(1, 0, 4'(i + 2), "R2");
        step(1, 1, 4'hA, "R11");
        step(1, 1, 4'hB, "R11");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 4'h0, "R11");
    endtask

    task automatic t_both_empty();
        step(1, 1, 4'h5, "R10");
        step(0, 1, 4'h0, "R3");
        step(1, 1, 4'h0, "R10");
        check("R10", "top_word zero word", int'(top_word), 0);
        step(0, 1, 4'h0, "R3");
    endtask

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "fill_level at start", int'(fill_level), 0);
        check("R1", "is_empty at start",   int'(is_empty), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R7");
        t_reset();
        t_underflow();
        t_fill_drain();
        t_overflow();
        t_swap_mid();
        t_swap_full();
        t_both_empty();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule